// File: doc/BRIEF.md
# Bus Controller Message Sequencer

This block runs the controller side of one message on a dual-redundant serial command/response bus. A falling edge on the active-low start input begins a message. The sequencer then reads a protocol control word from host memory, followed by one command word, or two for a terminal-to-terminal transfer. For a receive message it also reads the outbound data words. Each word reaches the serial encoder through a valid/ready word port. Replies from the decoder arrive on a single-cycle receive strobe. These replies are the looped-back copy of the last word sent, the responding status words and any inbound data. The sequencer writes every reply back to memory at consecutive addresses, in an order set by the message direction.

The control word picks the bus channel and the message flavour: broadcast, mode code or terminal-to-terminal. The sequencer checks the looped word against what it sent, and each status word's terminal address against the commanded address. It bounds each wait for a reply with a response timer. Start-of-message and end-of-message strobes frame each transfer. The error flags stay set until the next start.

Top module: `bc_msg_seq`

## Requirements
- R1: A falling edge on `start_n` while idle gives a one-cycle `som` pulse, and the first memory read is from address 0 (the control word). `som` and `eom` are never high together.
- R2: Memory reads run at consecutive addresses: control word, then the command words, then (receive messages only) the data words. A word-count field of 0 means 32 data words; the field is command bits [4:0].
- R3: After reset, `chan_vld` is 0. From the cycle after the first command word is read until end of message, `chan_vld` is 1 and `chan_a` equals control bit 7 (1 = bus A, 0 = bus B). Both are 0 whenever `eom` is high.
- R4: Receive message (command bit 10 = 0): after the reads, the looped word is written at the next address and the status word after it.
- R5: Transmit message (command bit 10 = 1): the looped command is written at address 2, the status word at 3, and the inbound data words from 4 onward.
- R6: With control bit 1 (broadcast) set, no status is awaited: `eom` follows the looped-word write and no further write occurs.
- R7: With control bit 0 (terminal-to-terminal) set, commands are read from addresses 1 (receive command) and 2 (transmit command), and both are sent in that order. The writes are the looped transmit command, the transmitting terminal's status, its data words (count from the transmit command), then the receiving terminal's status.
- R8: With control bit 2 (mode code) set, the word-count field is a mode code. Codes 0–15 carry no data word, and codes 16–31 carry exactly one.
- R9: A status word whose bits [15:11] differ from the address of the command it answers sets `stat_err`, and the message still completes with all writes.
- R10: If no reply arrives within `TMO_CYC` cycles of waiting, `tmo_err` is set, `eom` follows, and no further write occurs.
- R11: A looped word that differs from the last word sent sets `msg_err`. The received value is still the one written to memory.
- R12: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.
- R13: The words on `tx_data` appear in message order, and an offered word stays stable until `tx_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low message start |
| mem_req | output | 1 | Host memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address within the message block |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| tx_vld | output | 1 | Word offered to the encoder |
| tx_data | output | 16 | Word to transmit |
| tx_rdy | input | 1 | Encoder accepts the word |
| rx_vld | input | 1 | Decoded word strobe |
| rx_data | input | 16 | Decoded word |
| chan_a | output | 1 | Active channel: 1 = A, 0 = B |
| chan_vld | output | 1 | Channel output is valid |
| som | output | 1 | Start-of-message pulse |
| eom | output | 1 | End-of-message pulse |
| msg_err | output | 1 | Loop-back mismatch flag |
| stat_err | output | 1 | Status address mismatch flag |
| tmo_err | output | 1 | Response timeout flag |

## Verification
Directed messages cover each branch of the memory image: receive with a few words and with a zero count (32 words), transmit, broadcast, terminal-to-terminal, and mode codes on either side of 16. A wrong read count, write address or write order separates these branches from one another. Fault cases corrupt the looped word, skew a status address, and withhold a status or a data word. These show that each flag is set by its own cause only, and that a timeout cuts the write sequence at the right place. Randomly drawn direction, count, channel and memory latency then test the address arithmetic and the handshake stability.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W = 6;
  // control word bit positions
  localparam int CTL_CHAN_A = 7;
  localparam int CTL_MCODE = 2;
  localparam int CTL_BCAST = 1;
  localparam int CTL_RTRT = 0;
  // command word transmit/receive bit
  localparam int CMD_TR = 10;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_RD_CMD, S_TX_CMD, S_RD_DAT, S_TX_DAT, S_ECHO,
    S_WR_LOOP, S_WAIT_ST, S_WR_ST, S_WAIT_DAT, S_WR_DAT, S_DONE
  } seq_state_t;

  function automatic logic [CNT_W-1:0] data_count(input logic [4:0] wc, input logic mcode);
    if (mcode) data_count = {{(CNT_W-1){1'b0}}, wc[4]};
    else if (wc == 5'd0) data_count = CNT_W'(32);
    else data_count = {1'b0, wc};
  endfunction
endpackage

// File: rtl/bc_resp_timer.sv
module bc_resp_timer #(
  parameter int LIMIT = 168
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // a wait that reaches the limit must not keep counting past it
  assert_tmo_window_R10: assert property (@(posedge clk) disable iff (rst)
    expired |=> !(en && cnt == '0 && $past(en)) || !en);
endmodule

// File: rtl/bc_status_chk.sv
module bc_status_chk (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        chk_vld,
  input  logic [15:0] word,
  input  logic [4:0]  exp_addr,
  output logic        stat_err
);
  always_ff @(posedge clk) begin
    if (rst || clr) stat_err <= 1'b0;
    else if (chk_vld && word[15:11] != exp_addr) stat_err <= 1'b1;
  end

  assert_stat_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    stat_err && !clr |=> stat_err);
endmodule

// File: rtl/bc_msg_seq.sv
module bc_msg_seq
  import bc_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TMO_CYC = 168
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              tx_vld,
  output logic [15:0]       tx_data,
  input  logic              tx_rdy,
  input  logic              rx_vld,
  input  logic [15:0]       rx_data,
  output logic              chan_a,
  output logic              chan_vld,
  output logic              som,
  output logic              eom,
  output logic              msg_err,
  output logic              stat_err,
  output logic              tmo_err
);
  seq_state_t st;
  logic start_q, go;
  logic c_rtrt, c_bcast, c_mode;
  logic [WORD_W-1:0] cmd1, cmd2, last_tx;
  logic idx;
  logic [CNT_W-1:0] cnt, ndata;
  logic waiting, expired, rx_msg, st_chk;
  logic [4:0] exp_st_addr;

  assign go = start_q && !start_n && st == S_IDLE;
  assign rx_msg = !c_rtrt && !cmd1[CMD_TR];
  assign ndata = data_count(c_rtrt ? cmd2[4:0] : cmd1[4:0], c_mode);
  assign exp_st_addr = (c_rtrt && !idx) ? cmd2[15:11] : cmd1[15:11];
  assign waiting = (st == S_ECHO) || (st == S_WAIT_ST) || (st == S_WAIT_DAT);
  assign st_chk = (st == S_WAIT_ST) && rx_vld;

  assign mem_req = st inside {S_RD_CTL, S_RD_CMD, S_RD_DAT, S_WR_LOOP, S_WR_ST, S_WR_DAT};
  assign mem_we  = st inside {S_WR_LOOP, S_WR_ST, S_WR_DAT};
  assign tx_vld  = st inside {S_TX_CMD, S_TX_DAT};

  bc_resp_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(waiting && !rx_vld), .expired(expired));

  bc_status_chk u_stchk (
    .clk(clk), .rst(rst), .clr(go), .chk_vld(st_chk), .word(rx_data),
    .exp_addr(exp_st_addr), .stat_err(stat_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; start_q <= 1'b1;
      c_rtrt <= 1'b0; c_bcast <= 1'b0; c_mode <= 1'b0;
      cmd1 <= '0; cmd2 <= '0; last_tx <= '0; tx_data <= '0; mem_wdata <= '0;
      mem_addr <= '0; idx <= 1'b0; cnt <= '0;
      chan_a <= 1'b0; chan_vld <= 1'b0; som <= 1'b0; eom <= 1'b0;
      msg_err <= 1'b0; tmo_err <= 1'b0;
    end else begin
      start_q <= start_n;
      som <= 1'b0;
      eom <= 1'b0;
      if (mem_req && mem_ack) mem_addr <= mem_addr + 1'b1;
      case (st)
        S_IDLE: if (go) begin
          som <= 1'b1; mem_addr <= '0; msg_err <= 1'b0; tmo_err <= 1'b0;
          idx <= 1'b0; st <= S_RD_CTL;
        end
        S_RD_CTL: if (mem_ack) begin
          c_rtrt <= mem_rdata[CTL_RTRT]; c_bcast <= mem_rdata[CTL_BCAST];
          c_mode <= mem_rdata[CTL_MCODE];
          chan_a <= mem_rdata[CTL_CHAN_A];
          st <= S_RD_CMD;
        end
        S_RD_CMD: if (mem_ack) begin
          cnt <= '0;
          if (!idx) begin
            cmd1 <= mem_rdata; chan_vld <= 1'b1;
          end else begin
            cmd2 <= mem_rdata;
          end
          if (c_rtrt && !idx) idx <= 1'b1;
          else begin
            idx <= 1'b0;
            tx_data <= idx ? cmd1 : mem_rdata;
            st <= S_TX_CMD;
          end
        end
        S_TX_CMD: if (tx_rdy) begin
          last_tx <= tx_data;
          if (c_rtrt && !idx) begin
            idx <= 1'b1; tx_data <= cmd2;
          end else if (rx_msg && ndata != '0) st <= S_RD_DAT;
          else st <= S_ECHO;
        end
        S_RD_DAT: if (mem_ack) begin
          tx_data <= mem_rdata; st <= S_TX_DAT;
        end
        S_TX_DAT: if (tx_rdy) begin
          last_tx <= tx_data;
          cnt <= cnt + 1'b1;
          st <= (cnt + 6'd1 == ndata) ? S_ECHO : S_RD_DAT;
        end
        S_ECHO: if (rx_vld) begin
          if (rx_data != last_tx) msg_err <= 1'b1;
          mem_wdata <= rx_data; st <= S_WR_LOOP;
        end else if (expired) begin
          tmo_err <= 1'b1; st <= S_DONE;
        end
        S_WR_LOOP: if (mem_ack) begin
          idx <= 1'b0; cnt <= '0;
          st <= c_bcast ? S_DONE : S_WAIT_ST;
        end
        S_WAIT_ST: if (rx_vld) begin
          mem_wdata <= rx_data; st <= S_WR_ST;
        end else if (expired) begin
          tmo_err <= 1'b1; st <= S_DONE;
        end
        S_WR_ST: if (mem_ack) begin
          if (rx_msg || idx) st <= S_DONE;
          else if (ndata != '0) st <= S_WAIT_DAT;
          else if (c_rtrt) begin
            idx <= 1'b1; st <= S_WAIT_ST;
          end else st <= S_DONE;
        end
        S_WAIT_DAT: if (rx_vld) begin
          mem_wdata <= rx_data; cnt <= cnt + 1'b1; st <= S_WR_DAT;
        end else if (expired) begin
          tmo_err <= 1'b1; st <= S_DONE;
        end
        S_WR_DAT: if (mem_ack) begin
          if (cnt != ndata) st <= S_WAIT_DAT;
          else if (c_rtrt) begin
            idx <= 1'b1; st <= S_WAIT_ST;
          end else st <= S_DONE;
        end
        S_DONE: begin
          eom <= 1'b1; chan_vld <= 1'b0; chan_a <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_som_eom_R1: assert property (@(posedge clk) disable iff (rst) !(som && eom));
  assert_eom_chan_R3: assert property (@(posedge clk) disable iff (rst) eom |-> !chan_vld && !chan_a);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (rst)
    tx_vld && !tx_rdy |=> tx_vld && $stable(tx_data));
  assert_tmo_end_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |=> eom);
endmodule

// File: tb/tb_bc_msg_seq.sv
module tb_bc_msg_seq;
  logic clk = 1'b0, rst = 1'b1, start_n = 1'b1;
  logic mem_req, mem_we, mem_ack = 1'b0, tx_vld, tx_rdy = 1'b0, rx_vld = 1'b0;
  logic [5:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, tx_data, rx_data = '0;
  logic chan_a, chan_vld, som, eom, msg_err, stat_err, tmo_err;

  always #5 clk = ~clk;

  bc_msg_seq dut (.clk(clk), .rst(rst), .start_n(start_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_vld(tx_vld), .tx_data(tx_data), .tx_rdy(tx_rdy), .rx_vld(rx_vld), .rx_data(rx_data),
    .chan_a(chan_a), .chan_vld(chan_vld), .som(som), .eom(eom), .msg_err(msg_err),
    .stat_err(stat_err), .tmo_err(tmo_err));

  logic [15:0] mem [0:63];
  assign mem_rdata = mem[mem_addr];

  int checks = 0, fails = 0, cyc = 0, hold_viol = 0, tx_viol = 0;
  int ntx, nw, nr, nsom, neom;
  logic [15:0] txl [0:63];
  logic [15:0] wld [0:63];
  logic [5:0] wla [0:63], rla [0:63];
  logic first_a, first_v;
  logic [15:0] etx [0:63];
  logic [15:0] ewd [0:63];
  int netx, new_n, nrd;
  logic bad_stat = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and hold monitor
  logic pend = 1'b0;
  logic [5:0] pend_addr;
  logic [15:0] pend_data;
  always @(negedge clk) begin
    if (pend && mem_req && (mem_addr != pend_addr || (mem_we && mem_wdata != pend_data))) hold_viol++;
    if (mem_req && !mem_ack && ($urandom % 3 != 0)) mem_ack = 1'b1;
    else mem_ack = 1'b0;
    pend = mem_req && !mem_ack;
    pend_addr = mem_addr; pend_data = mem_wdata;
  end

  logic tx_pend = 1'b0;
  logic [15:0] tx_prev;
  always @(negedge clk) begin
    if (tx_pend && (!tx_vld || tx_data != tx_prev)) tx_viol++;
    tx_rdy = ($urandom % 2) == 1;
    tx_pend = tx_vld && !tx_rdy;
    tx_prev = tx_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (nw < 64) begin wla[nw] = mem_addr; wld[nw] = mem_wdata; end
        nw++;
      end else begin
        if (nr < 64) rla[nr] = mem_addr;
        nr++;
      end
    end
    if (tx_vld && tx_rdy) begin
      if (ntx == 0) begin first_a = chan_a; first_v = chan_vld; end
      if (ntx < 64) txl[ntx] = tx_data;
      ntx++;
    end
    if (som) nsom++;
    if (eom) neom++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int nwords(input logic [4:0] wc, input logic mc);
    if (mc) return int'(wc[4]);
    return (wc == 5'd0) ? 32 : int'(wc);
  endfunction

  function automatic logic [15:0] mkcmd(input int a, input bit tr, input int wc);
    return {5'(a), tr, 5'($urandom % 32), 5'(wc)};
  endfunction

  function automatic logic [15:0] mkstat(input logic [15:0] c, input bit bad);
    return {c[15:11] ^ {4'b0, bad}, 11'($urandom)};
  endfunction

  task automatic run_msg(input logic [15:0] ctl, input logic [15:0] c1, input logic [15:0] c2,
                         input logic [15:0] corrupt, input int drop_at, input string tag);
    bit rtrt, bc, mc, rxm;
    int nd, k, base, guard;
    logic [15:0] last;
    rtrt = ctl[0]; bc = ctl[1]; mc = ctl[2];
    rxm = !rtrt && !c1[10];
    nd = nwords(rtrt ? c2[4:0] : c1[4:0], mc);
    mem[0] = ctl; mem[1] = c1; netx = 0; new_n = 0;
    etx[netx++] = c1;
    if (rtrt) begin mem[2] = c2; etx[netx++] = c2; end
    base = rtrt ? 3 : 2;
    if (rxm) for (int i = 0; i < nd; i++) begin
      mem[base + i] = 16'($urandom); etx[netx++] = mem[base + i];
    end
    nrd = rxm ? 2 + nd : base;
    last = etx[netx - 1];
    ewd[new_n++] = last ^ corrupt;
    if (!bc) begin
      ewd[new_n++] = mkstat(rtrt ? c2 : c1, bad_stat);
      if (!rxm) for (int i = 0; i < nd; i++) ewd[new_n++] = 16'($urandom);
      if (rtrt) ewd[new_n++] = mkstat(c1, 1'b0);
    end
    ntx = 0; nw = 0; nr = 0; nsom = 0; neom = 0;
    @(negedge clk) start_n = 1'b0;
    @(negedge clk) start_n = 1'b1;
    guard = 0;
    while (ntx < netx && guard < 3000) begin @(negedge clk); guard++; end
    for (int i = 0; i < new_n && i != drop_at; i++) begin
      guard = 0;
      while (nw < i && guard < 3000) begin @(negedge clk); guard++; end
      rx_vld = 1'b1; rx_data = ewd[i];
      @(negedge clk) rx_vld = 1'b0;
    end
    guard = 0;
    while (neom == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    k = (drop_at >= 0) ? drop_at : new_n;
    chk(nsom == 1 && neom == 1, "R1 som/eom count", 32'(nsom * 16 + neom), 32'h11);
    begin
      bit ok = (nr == nrd);
      for (int i = 0; i < nr && i < 64; i++) if (rla[i] != 6'(i)) ok = 0;
      chk(ok, "R2 read order", 32'(nr), 32'(nrd));
    end
    begin
      bit ok = (ntx == netx);
      for (int i = 0; i < netx && ok; i++) if (txl[i] != etx[i]) ok = 0;
      chk(ok, {"R13 tx order ", tag}, 32'(ntx), 32'(netx));
    end
    begin
      bit ok = (nw == k);
      for (int i = 0; i < k && ok; i++) if (wla[i] != 6'(nrd + i) || wld[i] != ewd[i]) ok = 0;
      chk(ok, {tag, " write image"}, 32'(nw), 32'(k));
    end
    chk(first_v && first_a == ctl[7], "R3 channel during message", {30'b0, first_v, first_a}, {30'b0, 1'b1, ctl[7]});
    chk(!chan_vld, "R3 channel cleared after eom", 32'(chan_vld), 32'd0);
    chk(msg_err == (corrupt != 0), "R11 msg_err", 32'(msg_err), 32'(corrupt != 0));
    chk(stat_err == (bad_stat && !bc && drop_at != 1), "R9 stat_err", 32'(stat_err), 32'(bad_stat && !bc));
    chk(tmo_err == (drop_at >= 0), "R10 tmo_err", 32'(tmo_err), 32'(drop_at >= 0));
  endtask

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !tx_vld && !chan_vld && !som && !eom && !msg_err && !stat_err && !tmo_err,
        "R3 reset state", {28'b0, mem_req, tx_vld, chan_vld, eom}, 32'd0);
    // receive, few words, bus A
    run_msg(16'h0080, mkcmd(3, 0, 3), 16'h0, 16'h0, -1, "R4 rx 3");
    // receive with zero count -> 32 words, bus B
    run_msg(16'h0000, mkcmd(7, 0, 0), 16'h0, 16'h0, -1, "R2 R4 rx 32");
    // transmit
    run_msg(16'h0080, mkcmd(12, 1, 4), 16'h0, 16'h0, -1, "R5 tx 4");
    // broadcast receive
    run_msg(16'h0082, mkcmd(31, 0, 2), 16'h0, 16'h0, -1, "R6 bcast");
    // terminal to terminal
    run_msg(16'h0001, mkcmd(4, 0, 2), mkcmd(9, 1, 2), 16'h0, -1, "R7 rtrt");
    // mode codes on both sides of 16
    run_msg(16'h0084, mkcmd(5, 0, 17), 16'h0, 16'h0, -1, "R8 mode 17");
    run_msg(16'h0004, mkcmd(5, 1, 2), 16'h0, 16'h0, -1, "R8 mode 2");
    // status address mismatch
    bad_stat = 1'b1;
    run_msg(16'h0080, mkcmd(6, 1, 2), 16'h0, 16'h0, -1, "R9 bad status");
    bad_stat = 1'b0;
    // timeouts: missing status, missing data word
    run_msg(16'h0000, mkcmd(8, 1, 3), 16'h0, 16'h0, 1, "R10 no status");
    run_msg(16'h0080, mkcmd(8, 1, 3), 16'h0, 16'h0, 3, "R10 no data");
    // corrupted loop-back
    run_msg(16'h0080, mkcmd(2, 0, 1), 16'h0, 16'h0100, -1, "R11 loop");
    // random mix
    for (int n = 0; n < 16; n++) begin
      bit tr = ($urandom % 2) == 1;
      run_msg({8'b0, 1'($urandom), 7'b0}, mkcmd(int'($urandom % 31), tr, int'($urandom % 32)),
              16'h0, 16'h0, -1, tr ? "R5 random" : "R4 random");
    end
    chk(hold_viol == 0, "R12 memory hold", 32'(hold_viol), 32'd0);
    chk(tx_viol == 0, "R13 tx hold", 32'(tx_viol), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule